// File: doc/BRIEF.md
# Triggered Snapshot Capture Controller

This block records a burst of 16-bit sample words into a small on-chip memory. The memory is split into an A half and a B half. A host sets a control word through a simple synchronous register port. That word holds the start condition, the read format and an arm bit. Once armed, the block waits for the chosen start condition: either no wait at all, or one of three external start strobes. When the condition is met, the block clears the arm bit on its own and begins storing valid samples at consecutive addresses.

Each half of the memory has its own completion flag. A flag is raised by the block and stays raised until the host writes a zero to it. Capture stops once the B half is full, and later samples are dropped. The host then reads the captured words back through a pointer that advances by itself. Each read returns a full word, or the low byte or high byte of the word sign-extended to 16 bits.

Top module: `snap_capture`

## Requirements
- R1: Control bits 1:0 choose the start condition: code 0 starts on the first clock edge at which the arm bit is set; codes 1, 2 and 3 start on the first edge at which `start_s1`, `start_s2` or `start_s3` is high while armed. Strobes not chosen have no effect.
- R2: Control bit 4 is the arm bit. A host write sets or clears it. The block clears it on the same edge on which the capture starts, and capture never starts while it is clear.
- R3: Control bit 5 goes high once the first DEPTH/2 samples have been stored. Control bit 6 goes high once all DEPTH samples have been stored.
- R4: A host control write that puts 1 in bit 5 or bit 6 leaves that flag unchanged. A write of 0 clears it. When the block sets a flag on the same edge as a host write of 0 to it, the flag ends up set.
- R5: `reg_sel` = 0 addresses the control word and `reg_sel` = 1 addresses the capture data. The result of a read appears on `reg_rdata` one clock after `reg_rd` is sampled high, and it holds until the next read. Control bits 3:2 hold the read format. Bits 15:7 of the control word read as zero.
- R6: After a start, each sample with `smp_valid` high is stored at addresses 0, 1, 2 and so on. Storing stops after DEPTH samples, and samples arriving after that are not stored.
- R7: Read format codes 0 and 2 return the stored 16-bit word unchanged.
- R8: Read format code 1 returns the low byte, and code 3 returns the high byte, in bits 7:0. Bit 7 of that byte is copied into bits 15:8.
- R9: Each data read returns the word at the read pointer and then advances the pointer, wrapping from DEPTH-1 to 0. Every control write returns the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample word valid this cycle |
| smp_data | input | 16 | Sample word |
| start_s1 | input | 1 | Start strobe chosen by condition code 1 |
| start_s2 | input | 1 | Start strobe chosen by condition code 2 |
| start_s3 | input | 1 | Start strobe chosen by condition code 3 |
| reg_wr | input | 1 | Host write strobe (control word only) |
| reg_rd | input | 1 | Host read strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects capture data |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Registered host read data |

## Verification
The hardest case to reach from the ports is a host write that clears the A-half flag on the very edge on which the block sets it. The bench reaches it with start code 0 and a valid strobe held high without a break. This fixes the edge that stores sample DEPTH/2-1 two clocks past the arming edge plus DEPTH/2-1 cycles. The bench places a control write of zero exactly on that edge. Every start code is also run with the strobes that were not chosen pulsed first. Readback then goes through all four formats on patterns whose bytes take both signs.

// File: rtl/snap_pkg.sv
package snap_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        START_NOW = 2'd0,
        START_S1  = 2'd1,
        START_S2  = 2'd2,
        START_S3  = 2'd3
    } start_sel_e;

    typedef enum logic [1:0] {
        FMT_WORD  = 2'd0,
        FMT_LOB   = 2'd1,
        FMT_WORD2 = 2'd2,
        FMT_HIB   = 2'd3
    } rd_fmt_e;

    // Bit positions within the host-visible control word
    localparam int BIT_ARM   = 4;
    localparam int BIT_ADONE = 5;
    localparam int BIT_BDONE = 6;

endpackage

// File: rtl/snap_ctrl.sv
module snap_ctrl
    import snap_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int HALF = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [WORD_W-1:0] ctrl_wdata,
    input  logic [2:0]        strobes,
    input  logic              smp_valid,
    output logic [WORD_W-1:0] ctrl_word,
    output rd_fmt_e           rd_fmt,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic              arm_o,
    output logic              adone_o,
    output logic              bdone_o,
    output logic              cap_o
);

    typedef struct packed {
        start_sel_e    start;
        rd_fmt_e       fmt;
        logic          arm;
        logic          adone;
        logic          bdone;
        logic          cap;
        logic [AW-1:0] wptr;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        hit;
    logic        fire;
    logic        set_a;
    logic        set_b;

    always_comb begin
        st_d = st_q;

        // Start condition multiplexer
        unique case (st_q.start)
            START_NOW: hit = 1'b1;
            START_S1:  hit = strobes[0];
            START_S2:  hit = strobes[1];
            default:   hit = strobes[2];
        endcase

        fire      = st_q.arm && !st_q.cap && hit;
        mem_we    = st_q.cap && smp_valid;
        mem_waddr = st_q.wptr;
        set_a     = mem_we && (st_q.wptr == AW'(HALF - 1));
        set_b     = mem_we && (st_q.wptr == AW'(DEPTH - 1));

        if (fire) begin
            st_d.arm  = 1'b0;
            st_d.cap  = 1'b1;
            st_d.wptr = '0;
        end

        if (mem_we) begin
            st_d.wptr = st_q.wptr + AW'(1);
            if (set_b) begin
                st_d.cap = 1'b0;
            end
        end

        if (ctrl_wr) begin
            st_d.start = start_sel_e'(ctrl_wdata[1:0]);
            st_d.fmt   = rd_fmt_e'(ctrl_wdata[3:2]);
            st_d.arm   = ctrl_wdata[BIT_ARM];
            st_d.adone = st_q.adone & ctrl_wdata[BIT_ADONE];
            st_d.bdone = st_q.bdone & ctrl_wdata[BIT_BDONE];
        end

        // Hardware set has priority over a host clear
        st_d.adone = st_d.adone | set_a;
        st_d.bdone = st_d.bdone | set_b;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{start: START_NOW, fmt: FMT_WORD, arm: 1'b0, adone: 1'b0,
                      bdone: 1'b0, cap: 1'b0, wptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctrl_word            = '0;
        ctrl_word[1:0]       = st_q.start;
        ctrl_word[3:2]       = st_q.fmt;
        ctrl_word[BIT_ARM]   = st_q.arm;
        ctrl_word[BIT_ADONE] = st_q.adone;
        ctrl_word[BIT_BDONE] = st_q.bdone;
    end

    assign rd_fmt  = st_q.fmt;
    assign arm_o   = st_q.arm;
    assign adone_o = st_q.adone;
    assign bdone_o = st_q.bdone;
    assign cap_o   = st_q.cap;

endmodule

// File: rtl/snap_mem.sv
module snap_mem
    import snap_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/snap_rdport.sv
module snap_rdport
    import snap_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_data_sel,
    input  logic              ptr_clr,
    input  rd_fmt_e           rd_fmt,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [AW-1:0]     mem_raddr,
    output logic [WORD_W-1:0] rdata
);

    typedef struct packed {
        logic [AW-1:0]     ptr;
        logic [WORD_W-1:0] rdata;
    } rd_state_t;

    rd_state_t         rs_d, rs_q;
    logic [WORD_W-1:0] shaped;

    function automatic logic [WORD_W-1:0] sext_byte(input logic [BYTE_W-1:0] b);
        return {{(WORD_W - BYTE_W){b[BYTE_W-1]}}, b};
    endfunction

    always_comb begin
        unique case (rd_fmt)
            FMT_LOB: shaped = sext_byte(mem_rdata[BYTE_W-1:0]);
            FMT_HIB: shaped = sext_byte(mem_rdata[WORD_W-1:BYTE_W]);
            default: shaped = mem_rdata;
        endcase
    end

    always_comb begin
        rs_d = rs_q;
        if (rd_en) begin
            if (rd_data_sel) begin
                rs_d.rdata = shaped;
                rs_d.ptr   = (rs_q.ptr == AW'(DEPTH - 1)) ? '0 : rs_q.ptr + AW'(1);
            end else begin
                rs_d.rdata = ctrl_word;
            end
        end
        if (ptr_clr) begin
            rs_d.ptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign mem_raddr = rs_q.ptr;
    assign rdata     = rs_q.rdata;

endmodule

// File: rtl/snap_capture.sv
module snap_capture
    import snap_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_valid,
    input  logic [15:0] smp_data,
    input  logic        start_s1,
    input  logic        start_s2,
    input  logic        start_s3,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        reg_sel,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata
);

    localparam int AW = $clog2(DEPTH);

    logic              ctrl_wr;
    logic [WORD_W-1:0] ctrl_word;
    rd_fmt_e           rd_fmt;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [AW-1:0]     mem_raddr;
    logic [WORD_W-1:0] mem_rdata;
    logic              arm_w;
    logic              adone_w;
    logic              bdone_w;
    logic              cap_w;

    assign ctrl_wr = reg_wr && !reg_sel;

    snap_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_wdata(reg_wdata),
        .strobes   ({start_s3, start_s2, start_s1}),
        .smp_valid (smp_valid),
        .ctrl_word (ctrl_word),
        .rd_fmt    (rd_fmt),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .arm_o     (arm_w),
        .adone_o   (adone_w),
        .bdone_o   (bdone_w),
        .cap_o     (cap_w)
    );

    snap_mem #(.DEPTH(DEPTH)) mem_i (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(smp_data),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

    snap_rdport #(.DEPTH(DEPTH)) rd_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (reg_rd),
        .rd_data_sel(reg_sel),
        .ptr_clr    (ctrl_wr),
        .rd_fmt     (rd_fmt),
        .ctrl_word  (ctrl_word),
        .mem_rdata  (mem_rdata),
        .mem_raddr  (mem_raddr),
        .rdata      (reg_rdata)
    );

endmodule

// File: rtl/snap_capture_chk.sv
module snap_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic        reg_sel,
    input logic [15:0] reg_wdata,
    input logic [15:0] reg_rdata,
    input logic        arm_q,
    input logic        adone_q,
    input logic        bdone_q,
    input logic        cap_q,
    input logic        mem_we,
    input logic        fmt_byte
);

    logic host_ctrl_wr;
    assign host_ctrl_wr = reg_wr && !reg_sel;

    // R2: arm falls without a host write only when a capture begins
    p_arm_self_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(arm_q) && !$past(host_ctrl_wr)) |-> cap_q);

    // R2: capture never begins unless armed
    p_start_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cap_q) |-> $past(arm_q));

    // R4: flags only drop on a host write of zero
    p_adone_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adone_q && !(host_ctrl_wr && !reg_wdata[5])) |=> adone_q);

    p_bdone_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bdone_q && !(host_ctrl_wr && !reg_wdata[6])) |=> bdone_q);

    // R6: storing ends when the B half completes
    p_stop_at_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bdone_q) |-> !cap_q);

    // R6: no memory write outside a capture
    p_idle_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_q |-> !mem_we);

    // R5: unused control bits read zero
    p_ctrl_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && !reg_sel) |-> (reg_rdata[15:7] == 9'd0));

    // R8: byte formats carry a sign-extended upper byte
    p_byte_sext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd && reg_sel && fmt_byte) |-> (reg_rdata[15:8] == {8{reg_rdata[7]}}));

endmodule

bind snap_capture snap_capture_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_sel  (reg_sel),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .arm_q    (arm_w),
    .adone_q  (adone_w),
    .bdone_q  (bdone_w),
    .cap_q    (cap_w),
    .mem_we   (mem_we),
    .fmt_byte (rd_fmt[0])
);

// File: tb/snap_capture_tb_top.sv
module snap_capture_tb_top;

    localparam int DEPTH = 8;
    localparam int HALF  = DEPTH / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        start_s1 = 1'b0;
    logic        start_s2 = 1'b0;
    logic        start_s3 = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int errors = 0;
    int checks = 0;
    logic [15:0] exp_mem [DEPTH];

    always #2.5 clk = ~clk;

    snap_capture #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .start_s1(start_s1), .start_s2(start_s2), .start_s3(start_s3),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    function automatic logic [15:0] pat(int run, int i);
        logic [7:0] hi, lo;
        hi = 8'(8'h85 + i * 29 + run * 7);
        lo = 8'(8'hC3 ^ (i * 53 + run * 11));
        return {hi, lo};
    endfunction

    function automatic logic [15:0] shape(int f, logic [15:0] w);
        if (f == 1) return {{8{w[7]}}, w[7:0]};
        if (f == 3) return {{8{w[15]}}, w[15:8]};
        return w;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic sel, output logic [15:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = sel;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic push(logic [15:0] d);
        @(negedge clk);
        smp_valid = 1'b1; smp_data = d;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic pulse(int n);
        @(negedge clk);
        start_s1 = (n == 1); start_s2 = (n == 2); start_s3 = (n == 3);
        @(negedge clk);
        start_s1 = 1'b0; start_s2 = 1'b0; start_s3 = 1'b0;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(1'b0, v);
        check("R5 reset control word", v, 16'h0000);

        for (int m = 0; m < 4; m++) begin
            wr_ctrl(16'h0010 | 16'(m));
            if (m != 0) begin
                for (int o = 1; o < 4; o++) if (o != m) pulse(o);
                push(16'hDEAD);
                rd(1'b0, v);
                check("R1 unchosen strobes leave arm set", v, 16'h0010 | 16'(m));
                pulse(m);
            end else begin
                @(negedge clk);
            end
            rd(1'b0, v);
            check("R2 arm self-clears at start", v, 16'(m));

            for (int i = 0; i < DEPTH; i++) exp_mem[i] = pat(m, i);
            for (int i = 0; i < HALF; i++) push(exp_mem[i]);
            rd(1'b0, v);
            check("R3 A half flag", v, 16'h0020 | 16'(m));
            for (int i = HALF; i < DEPTH; i++) push(exp_mem[i]);
            rd(1'b0, v);
            check("R3 B half flag", v, 16'h0060 | 16'(m));
            push(16'h1234);
            push(16'h5678);

            for (int f = 0; f < 4; f++) begin
                logic [15:0] cw;
                cw = 16'h0060 | 16'(f << 2) | 16'(m);
                wr_ctrl(cw);
                rd(1'b0, v);
                check("R4 writing ones keeps flags", v, cw);
                for (int i = 0; i < DEPTH; i++) begin
                    rd(1'b1, v);
                    if (f == 1 || f == 3) check("R8 byte format sign extension", v, shape(f, exp_mem[i]));
                    else check("R7 R6 word readback", v, exp_mem[i]);
                end
                rd(1'b1, v);
                check("R9 pointer wraps", v, shape(f, exp_mem[0]));
                if (m == 0 && f == 2) begin
                    rd(1'b1, v);
                    wr_ctrl(cw);
                    rd(1'b1, v);
                    check("R9 control write resets pointer", v, exp_mem[0]);
                end
            end

            wr_ctrl(16'h0040);
            rd(1'b0, v);
            check("R4 zero clears A flag only", v, 16'h0040);
            wr_ctrl(16'h0000);
            rd(1'b0, v);
            check("R4 zero clears B flag", v, 16'h0000);
        end

        // R4 collision: host clear lands on the edge that sets the A flag
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 16'h0010;
        smp_valid = 1'b1; smp_data = 16'h0000;
        for (int c = 1; c <= DEPTH + 1; c++) begin
            @(negedge clk);
            reg_wr = (c == 1 + HALF);
            reg_wdata = 16'h0000;
            smp_data = (c >= 2) ? pat(9, c - 2) : 16'h0000;
        end
        @(negedge clk);
        smp_valid = 1'b0; reg_wr = 1'b0;
        rd(1'b0, v);
        check("R4 hardware set beats host clear", v, 16'h0060);
        rd(1'b1, v);
        check("R6 first stored sample at address 0", v, pat(9, 0));

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule